// File: doc/BRIEF.md
# Write Command Selector for Receive Bursts

This block sits next to a receive DMA engine that moves incoming data into host memory. Each time the engine is about to open a write burst, and again each time a running burst reaches a cache-line boundary, the engine pulses a strobe. The selector then looks at the programmed cache line size, the target address, how many dwords are waiting in the receive FIFO, how many dwords of room remain in the host buffer, and two enable bits. From these it decides whether the burst uses a plain memory write or a memory write and invalidate. An invalidate is chosen only when every condition holds together. Otherwise the block falls back to a plain write, and the data is still transferred.

At a line boundary inside an invalidate burst, the selector repeats the same test for the next line. It grants continuation only if that whole next line can also be written with the invalidate command. If it cannot, the engine closes the burst at the boundary and asks again with a start strobe. Plain-write bursts may always continue. All outputs are registered and appear one clock after the strobe.

Top module: `mwi_cmd_select`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cmd_code` is 4'b0111, and `be_all_on`, `cross_ok` and `dec_valid` are 0.
- R2: The invalidate command is chosen only when `cls_dw` equals 8 or 16. Any other value yields a plain write.
- R3: The invalidate command requires `addr` to be a multiple of the line size in bytes: `addr[4:0]` is zero for an 8-dword line and `addr[5:0]` is zero for a 16-dword line.
- R4: The invalidate command requires `fifo_dw` >= `cls_dw`.
- R5: The invalidate command requires `space_dw` >= `cls_dw`.
- R6: The invalidate command requires both bit 4 of `pci_cmd` and `ctl_mwi_en` to be 1.
- R7: `cmd_code` is 4'b1111 for memory write and invalidate and 4'b0111 for memory write. When any condition of R2 to R6 fails on a start strobe, the code is 4'b0111.
- R8: `be_all_on` is 1 exactly when the presented command is the invalidate code. This means all active-low byte enables are to be driven low.
- R9: On a boundary strobe inside an invalidate burst, `cross_ok` is 1 only when the conditions of R2 to R6 all hold for the next line. The command code and byte-enable indication keep their burst values.
- R10: On a boundary strobe inside a plain-write burst, `cross_ok` is 1.
- R11: Each strobe produces its decision on the clock after the strobe edge. `dec_valid` is high for exactly that cycle and low otherwise.
- R12: A start strobe clears `cross_ok` to 0. When `eval_start` and `eval_edge` are both high, the start strobe takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_start | input | 1 | Strobe: a new write burst is about to start |
| eval_edge | input | 1 | Strobe: running burst has reached a line boundary |
| cls_dw | input | CLS_W | Cache line size register, in dwords |
| addr | input | ADDR_W | Byte address of the line about to be written |
| fifo_dw | input | LVL_W | Receive FIFO fill level, in dwords |
| space_dw | input | LVL_W | Free space left in the host buffer, in dwords |
| pci_cmd | input | CMDR_W | Configuration command register; bit 4 enables invalidate writes |
| ctl_mwi_en | input | 1 | Invalidate enable from the controller's own configuration |
| cmd_code | output | 4 | Selected bus command code |
| be_all_on | output | 1 | Drive every byte enable active |
| cross_ok | output | 1 | Burst may continue into the next line |
| dec_valid | output | 1 | Decision outputs updated this cycle |

## Verification
The bench uses the default widths: 8-bit line size and level inputs, and a 12-bit address. The start sweep covers line sizes 0, 4, 8, 12, 16 and 32. It walks every address in 2-byte steps up to 80, so both misaligned bytes and misaligned lines of both legal sizes are covered. The FIFO and space levels are set one below, equal to and one above the line size, with all four enable combinations. Directed boundary sequences then cover continuation after invalidate and after plain starts, as well as simultaneous strobes.

// File: rtl/mwi_pkg.sv
package mwi_pkg;
  typedef enum logic [3:0] {
    CMD_MW  = 4'b0111,
    CMD_MWI = 4'b1111
  } bus_cmd_t;

  localparam int NUM_LINE_SIZES = 2;
  localparam int BASE_LINE_DW   = 8;
  localparam int MWI_EN_BIT     = 4;

  function automatic int line_dw_of(input int idx);
    return BASE_LINE_DW << idx;
  endfunction
endpackage

// File: rtl/mwi_line_check.sv
module mwi_line_check #(
  parameter int ADDR_W = 12,
  parameter int CLS_W  = 8
) (
  input  logic [CLS_W-1:0]  cls_dw,
  input  logic [ADDR_W-1:0] addr,
  output logic              size_ok,
  output logic              aligned
);
  import mwi_pkg::*;
  localparam int N = NUM_LINE_SIZES;

  logic [N-1:0] hit;
  logic [N-1:0] alg;

  generate
    for (genvar g = 0; g < N; g++) begin : g_size
      localparam int LW = line_dw_of(g);
      localparam int AB = $clog2(LW * 4);
      assign hit[g] = (cls_dw == CLS_W'(LW));
      assign alg[g] = (addr[AB-1:0] == '0);
    end
  endgenerate

  assign size_ok = |hit;
  assign aligned = |(hit & alg);
endmodule

// File: rtl/mwi_level_check.sv
module mwi_level_check #(
  parameter int LVL_W = 8,
  parameter int CLS_W = 8
) (
  input  logic [CLS_W-1:0] cls_dw,
  input  logic [LVL_W-1:0] fifo_dw,
  input  logic [LVL_W-1:0] space_dw,
  output logic             fifo_ok,
  output logic             space_ok
);
  localparam int CMP_W = (LVL_W > CLS_W) ? LVL_W : CLS_W;

  logic [CMP_W-1:0] need, have_f, have_s;
  assign need    = CMP_W'(cls_dw);
  assign have_f  = CMP_W'(fifo_dw);
  assign have_s  = CMP_W'(space_dw);
  assign fifo_ok  = (have_f >= need);
  assign space_ok = (have_s >= need);
endmodule

// File: rtl/mwi_decide.sv
module mwi_decide (
  input  logic       clk,
  input  logic       rst,
  input  logic       eval_start,
  input  logic       eval_edge,
  input  logic       size_ok,
  input  logic       aligned,
  input  logic       fifo_ok,
  input  logic       space_ok,
  input  logic       en_ok,
  output logic [3:0] cmd_code,
  output logic       be_all_on,
  output logic       cross_ok,
  output logic       dec_valid
);
  import mwi_pkg::*;

  logic all_ok;
  logic burst_mwi;
  assign all_ok = size_ok & aligned & fifo_ok & space_ok & en_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code  <= CMD_MW;
      be_all_on <= 1'b0;
      cross_ok  <= 1'b0;
      dec_valid <= 1'b0;
      burst_mwi <= 1'b0;
    end else begin
      dec_valid <= eval_start | eval_edge;
      if (eval_start) begin
        burst_mwi <= all_ok;
        cmd_code  <= all_ok ? CMD_MWI : CMD_MW;
        be_all_on <= all_ok;
        cross_ok  <= 1'b0;
      end else if (eval_edge) begin
        cross_ok <= burst_mwi ? all_ok : 1'b1;
      end
    end
  end

  assert_cls_R2: assert property (@(posedge clk) disable iff (rst)
    (eval_start && !size_ok) |=> (cmd_code == CMD_MW));
  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    (eval_start && !aligned) |=> (cmd_code == CMD_MW));
  assert_fifo_R4: assert property (@(posedge clk) disable iff (rst)
    (eval_start && !fifo_ok) |=> (cmd_code == CMD_MW));
  assert_space_R5: assert property (@(posedge clk) disable iff (rst)
    (eval_start && !space_ok) |=> (cmd_code == CMD_MW));
  assert_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (eval_start && !en_ok) |=> (cmd_code == CMD_MW));
  assert_be_match_R8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (be_all_on == (cmd_code == CMD_MWI)));
  assert_mw_cross_R10: assert property (@(posedge clk) disable iff (rst)
    (eval_edge && !eval_start && !burst_mwi) |=> cross_ok);
  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (eval_edge && !eval_start) |=> $stable(cmd_code));
  assert_valid_R11: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(eval_start || eval_edge));
  assert_start_clear_R12: assert property (@(posedge clk) disable iff (rst)
    eval_start |=> !cross_ok);
endmodule

// File: rtl/mwi_cmd_select.sv
module mwi_cmd_select #(
  parameter int ADDR_W = 12,
  parameter int CLS_W  = 8,
  parameter int LVL_W  = 8,
  parameter int CMDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_start,
  input  logic              eval_edge,
  input  logic [CLS_W-1:0]  cls_dw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  fifo_dw,
  input  logic [LVL_W-1:0]  space_dw,
  input  logic [CMDR_W-1:0] pci_cmd,
  input  logic              ctl_mwi_en,
  output logic [3:0]        cmd_code,
  output logic              be_all_on,
  output logic              cross_ok,
  output logic              dec_valid
);
  import mwi_pkg::*;

  logic size_ok, aligned, fifo_ok, space_ok, en_ok;
  assign en_ok = pci_cmd[MWI_EN_BIT] & ctl_mwi_en;

  mwi_line_check #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_line (
    .cls_dw (cls_dw),
    .addr   (addr),
    .size_ok(size_ok),
    .aligned(aligned)
  );

  mwi_level_check #(.LVL_W(LVL_W), .CLS_W(CLS_W)) u_level (
    .cls_dw  (cls_dw),
    .fifo_dw (fifo_dw),
    .space_dw(space_dw),
    .fifo_ok (fifo_ok),
    .space_ok(space_ok)
  );

  mwi_decide u_dec (
    .clk       (clk),
    .rst       (rst),
    .eval_start(eval_start),
    .eval_edge (eval_edge),
    .size_ok   (size_ok),
    .aligned   (aligned),
    .fifo_ok   (fifo_ok),
    .space_ok  (space_ok),
    .en_ok     (en_ok),
    .cmd_code  (cmd_code),
    .be_all_on (be_all_on),
    .cross_ok  (cross_ok),
    .dec_valid (dec_valid)
  );

  assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 4'b0111) || (cmd_code == 4'b1111));
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (cmd_code == 4'b0111 && !be_all_on && !cross_ok && !dec_valid));
endmodule

// File: tb/mwi_cmd_select_test.sv
module mwi_cmd_select_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval_start = 1'b0, eval_edge = 1'b0;
  logic [7:0]  cls_dw = '0;
  logic [11:0] addr = '0;
  logic [7:0]  fifo_dw = '0, space_dw = '0;
  logic [15:0] pci_cmd = '0;
  logic        ctl_mwi_en = 1'b0;
  logic [3:0]  cmd_code;
  logic        be_all_on, cross_ok, dec_valid;

  int errors = 0;
  int checks = 0;
  bit exp_burst_mwi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwi_cmd_select uut (
    .clk(clk), .rst(rst), .eval_start(eval_start), .eval_edge(eval_edge),
    .cls_dw(cls_dw), .addr(addr), .fifo_dw(fifo_dw), .space_dw(space_dw),
    .pci_cmd(pci_cmd), .ctl_mwi_en(ctl_mwi_en),
    .cmd_code(cmd_code), .be_all_on(be_all_on), .cross_ok(cross_ok),
    .dec_valid(dec_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cls=%0d addr=%0d fifo=%0d space=%0d)",
               req, act, exp, cls_dw, addr, fifo_dw, space_dw);
    end
  endtask

  function automatic bit exp_ok();
    bit sz, al;
    sz = (cls_dw == 8) || (cls_dw == 16);
    al = (cls_dw == 8)  ? (addr % 32 == 0) :
         (cls_dw == 16) ? (addr % 64 == 0) : 1'b0;
    return sz && al && (fifo_dw >= cls_dw) && (space_dw >= cls_dw) &&
           pci_cmd[4] && ctl_mwi_en;
  endfunction

  task automatic strobe(input bit s, input bit e);
    eval_start = s; eval_edge = e;
    @(posedge clk);
    @(negedge clk);
    eval_start = 0; eval_edge = 0;
  endtask

  task automatic do_start(input string req);
    bit ok;
    ok = exp_ok();
    strobe(1, 0);
    exp_burst_mwi = ok;
    chk(req, cmd_code, ok ? 4'hF : 4'h7);
    chk("R8", be_all_on, ok);
    chk("R12", cross_ok, 0);
    chk("R11", dec_valid, 1);
  endtask

  task automatic do_edge(input string req);
    bit ok;
    ok = exp_ok();
    strobe(0, 1);
    chk(req, cross_ok, exp_burst_mwi ? ok : 1'b1);
    chk("R9", cmd_code, exp_burst_mwi ? 4'hF : 4'h7);
    chk("R8", be_all_on, exp_burst_mwi);
    chk("R11", dec_valid, 1);
  endtask

  initial begin
    int cls_list[6] = '{0, 4, 8, 12, 16, 32};
    repeat (3) @(negedge clk);
    chk("R1", cmd_code, 4'h7);
    chk("R1", be_all_on, 0);
    chk("R1", cross_ok, 0);
    chk("R1", dec_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", cmd_code, 4'h7);
    chk("R11", dec_valid, 0);

    // Start sweep: R2 R3 R4 R5 R6 R7
    foreach (cls_list[ci]) begin
      for (int a = 0; a <= 40; a++) begin
        for (int f = -1; f <= 1; f++) begin
          for (int sp = -1; sp <= 1; sp++) begin
            for (int en = 0; en < 4; en++) begin
              cls_dw = 8'(cls_list[ci]);
              addr = 12'(a * 2);
              fifo_dw = 8'(cls_list[ci] + f);
              space_dw = 8'(cls_list[ci] + sp);
              pci_cmd = 16'hFFEF | (16'(en & 1) << 4);
              ctl_mwi_en = en[1];
              do_start("R7");
            end
          end
        end
      end
    end
    @(negedge clk);
    chk("R11", dec_valid, 0);

    // Boundary decisions: R9 R10
    for (int c = 0; c < 2; c++) begin
      for (int f = -1; f <= 1; f++) begin
        for (int sp = -1; sp <= 1; sp++) begin
          for (int st = 0; st < 2; st++) begin
            cls_dw = (c == 0) ? 8'd8 : 8'd16;
            addr = 12'd128;
            fifo_dw = 8'd40; space_dw = 8'd40;
            pci_cmd = 16'h0010; ctl_mwi_en = 1;
            if (st == 1) fifo_dw = 8'd1;
            do_start("R7");
            fifo_dw = 8'(int'(cls_dw) + f);
            space_dw = 8'(int'(cls_dw) + sp);
            addr = 12'd128 + 12'(cls_dw * 4);
            do_edge(st == 1 ? "R10" : "R9");
          end
        end
      end
    end
    // Boundary with misaligned address / enable dropped inside MWI burst: R9
    cls_dw = 8'd8; addr = 12'd0; fifo_dw = 8'd20; space_dw = 8'd20;
    pci_cmd = 16'h0010; ctl_mwi_en = 1;
    do_start("R7");
    addr = 12'd36;
    do_edge("R9");
    addr = 12'd32; ctl_mwi_en = 0;
    do_edge("R9");

    // Both strobes: R12
    cls_dw = 8'd16; addr = 12'd64; fifo_dw = 8'd16; space_dw = 8'd16;
    pci_cmd = 16'h0010; ctl_mwi_en = 1;
    do_start("R12");
    do_edge("R9");
    chk("R9", cross_ok, 1);
    fifo_dw = 8'd3;
    strobe(1, 1);
    exp_burst_mwi = 0;
    chk("R12", cross_ok, 0);
    chk("R12", cmd_code, 4'h7);
    chk("R12", dec_valid, 1);
    @(negedge clk);
    chk("R11", dec_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule